// File: doc/BRIEF.md
# Elastic Refresh Scheduler with Backlog-Dependent Idle Delay

This block decides when one DRAM rank should receive its next refresh. A period timer adds one owed refresh to a backlog counter every refresh interval. The scheduler waits for a stretch of quiet on the rank before it asks for a refresh, so that reads rarely run into a refresh that is in progress. How long it waits depends on how far behind it has fallen. With only a small debt it does not ask at all. In a middle band it waits a fixed idle delay. Closer to the limit the delay shrinks linearly with the debt. At the limit it raises an urgent flag and requests regardless of traffic.

The memory controller's command arbiter sees `ref_req`. It returns `ref_issued` in the cycle it accepts the request and sends the refresh command. From that edge the rank is reported busy for the refresh cycle time. The debt drops by one when that busy window closes. Command-bus arbitration and the DRAM device are outside this block.

Top module: `elastic_refresh_sched`

## Requirements
- R1: During and right after reset, `ref_req`, `ref_urgent` and `rank_busy` are 0 and `backlog` is 0.
- R2: `backlog` rises by one every `T_REFI` clock cycles. It saturates at `BL_MAX` (8 by default) and never exceeds it.
- R3: While `backlog` is below `ELIG_MIN` (2 by default), `ref_req` stays 0 however long the rank is idle.
- R4: While `backlog` is from `ELIG_MIN` to `RAMP_START`-1 (2 to 4 by default), `ref_req` rises once the rank has been idle with no pending request for `THR_FLAT` consecutive cycles (48 by default).
- R5: While `backlog` is from `RAMP_START` to `BL_MAX`-1 (5 to 7 by default), the idle delay is `THR_STEP`*(`BL_MAX`-`backlog`) cycles (16 per level by default: 48, 32, 16).
- R6: `ref_urgent` is 1 exactly when `backlog` equals `BL_MAX`. Then `ref_req` is 1 whenever the rank is not busy, even with `req_pending` high and `rank_idle` low.
- R7: A pulse on `ref_issued` while `ref_req` is 0 is ignored: `rank_busy` stays 0 and `backlog` is unchanged.
- R8: `ref_issued` together with `ref_req` makes `rank_busy` 1 from the next edge for exactly `T_RFC` cycles. `ref_req` is 0 throughout that window.
- R9: `backlog` falls by one at the edge where `rank_busy` returns to 0, and it never goes below 0.
- R10: Any cycle with `req_pending` high, `rank_idle` low or `rank_busy` high restarts the idle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rank_idle | input | 1 | Rank has no command activity this cycle |
| req_pending | input | 1 | Controller holds a request for this rank |
| ref_issued | input | 1 | Arbiter accepts the refresh request this cycle |
| ref_req | output | 1 | Refresh requested |
| ref_urgent | output | 1 | Refresh debt at its limit; request has priority over traffic |
| rank_busy | output | 1 | Rank occupied by a refresh in progress |
| backlog | output | $clog2(BL_MAX+1) | Number of refreshes currently owed |

## Verification
The assertions assume the arbiter raises `ref_issued` only as a reply to a visible request. They also assume `rank_idle` and `req_pending` are plain level inputs with no other ordering. The properties on the busy window and on ignored acceptances rely on this. The bench keeps inside these assumptions by driving inputs only on falling edges. It asserts `ref_issued` for a single cycle, and except in the one test of the ignored case, only while it observes `ref_req` high. It aligns each threshold measurement to a just-observed backlog increment, so no interval tick falls inside a measurement.

// File: rtl/refsched_pkg.sv
// Shared types for the elastic refresh scheduler.
package refsched_pkg;
    // Backlog band that selects how the idle delay is chosen.
    typedef enum logic [1:0] {
        RG_QUIET  = 2'd0,  // too little debt: never request
        RG_FLAT   = 2'd1,  // fixed idle delay
        RG_RAMP   = 2'd2,  // delay shrinks with debt
        RG_FORCED = 2'd3   // debt at limit: request unconditionally
    } refsched_region_e;
endpackage

// File: rtl/refsched_interval_timer.sv
// Refresh interval timer.
// Down-counter that emits a one-cycle tick every T_REFI cycles.
// Assumes T_REFI >= 2.
module refsched_interval_timer #(
    parameter int T_REFI = 1950
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = $clog2(T_REFI + 1);
    localparam logic [TW-1:0] RELOAD = TW'(T_REFI - 1);

    logic [TW-1:0] cnt;

    assign tick = (cnt == '0);

    // Count down and reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= RELOAD;
        else if (tick) cnt <= RELOAD;
        else           cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/refsched_backlog.sv
// Owed-refresh counter.
// Adds one per interval tick (saturating at BL_MAX) and removes one per
// completed refresh (never below zero). A tick and a completion in the
// same cycle cancel.
module refsched_backlog #(
    parameter int BL_MAX = 8,
    parameter int BL_W   = $clog2(BL_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            done,
    output logic [BL_W-1:0] backlog
);
    localparam logic [BL_W-1:0] TOP = BL_W'(BL_MAX);

    // Update the debt from the tick and completion events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            backlog <= '0;
        end else begin
            unique case ({tick, done})
                2'b10:   if (backlog != TOP) backlog <= backlog + 1'b1;
                2'b01:   if (backlog != '0)  backlog <= backlog - 1'b1;
                default: backlog <= backlog;
            endcase
        end
    end
endmodule

// File: rtl/refsched_idle_thresh.sv
// Idle counter and backlog-dependent threshold.
// Counts consecutive quiet cycles and classifies the backlog into a band.
// It raises thr_met when the band allows an opportunistic refresh and the
// idle count has reached that band's delay.
module refsched_idle_thresh
    import refsched_pkg::*;
#(
    parameter int BL_MAX     = 8,
    parameter int BL_W       = $clog2(BL_MAX + 1),
    parameter int ELIG_MIN   = 2,
    parameter int RAMP_START = 5,
    parameter int THR_FLAT   = 48,
    parameter int THR_STEP   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rank_idle,
    input  logic             req_pending,
    input  logic             busy,
    input  logic [BL_W-1:0]  backlog,
    output refsched_region_e region,
    output logic             thr_met
);
    localparam int IDLE_W = $clog2(THR_FLAT + THR_STEP * BL_MAX + 1) + 1;

    logic [IDLE_W-1:0] idle_cnt;
    logic [IDLE_W-1:0] thr;
    logic              quiet;

    assign quiet = rank_idle && !req_pending && !busy;

    // Count quiet cycles, restart on any activity, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || !quiet)   idle_cnt <= '0;
        else if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
    end

    // Classify the backlog into its band.
    always_comb begin
        if (int'(backlog) >= BL_MAX)          region = RG_FORCED;
        else if (int'(backlog) >= RAMP_START) region = RG_RAMP;
        else if (int'(backlog) >= ELIG_MIN)   region = RG_FLAT;
        else                                  region = RG_QUIET;
    end

    // Pick the idle delay for the band and compare.
    always_comb begin
        if (region == RG_RAMP) thr = IDLE_W'(THR_STEP * (BL_MAX - int'(backlog)));
        else                   thr = IDLE_W'(THR_FLAT);
        thr_met = ((region == RG_FLAT) || (region == RG_RAMP)) && (idle_cnt >= thr);
    end
endmodule

// File: rtl/refsched_rfc_busy.sv
// Refresh occupancy timer.
// Holds busy for T_RFC cycles from the edge that accepts a refresh.
// Pulses done in the last busy cycle. Assumes T_RFC >= 1.
module refsched_rfc_busy #(
    parameter int T_RFC = 88
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int RW = $clog2(T_RFC + 1);

    logic [RW-1:0] cnt;

    assign busy = (cnt != '0);
    assign done = (cnt == RW'(1));

    // Load on acceptance, then count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (start) cnt <= RW'(T_RFC);
        else if (busy)  cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/elastic_refresh_sched.sv
// Per-rank elastic refresh scheduler (top).
// Combines the interval timer, the debt counter, the idle threshold and
// the occupancy timer. It requests a refresh opportunistically after an
// idle delay set by the debt band, or unconditionally at the debt limit.
// Assumes ref_issued is only meaningful while ref_req is high.
module elastic_refresh_sched
    import refsched_pkg::*;
#(
    parameter int T_REFI     = 1950,
    parameter int T_RFC      = 88,
    parameter int BL_MAX     = 8,
    parameter int ELIG_MIN   = 2,
    parameter int RAMP_START = 5,
    parameter int THR_FLAT   = 48,
    parameter int THR_STEP   = 16,
    localparam int BL_W      = $clog2(BL_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rank_idle,
    input  logic            req_pending,
    input  logic            ref_issued,
    output logic            ref_req,
    output logic            ref_urgent,
    output logic            rank_busy,
    output logic [BL_W-1:0] backlog
);
    logic             tick;
    logic             done;
    logic             start;
    logic             thr_met;
    refsched_region_e region;

    refsched_interval_timer #(.T_REFI(T_REFI)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    refsched_backlog #(.BL_MAX(BL_MAX), .BL_W(BL_W)) u_backlog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .done(done), .backlog(backlog)
    );

    refsched_idle_thresh #(
        .BL_MAX(BL_MAX), .BL_W(BL_W), .ELIG_MIN(ELIG_MIN),
        .RAMP_START(RAMP_START), .THR_FLAT(THR_FLAT), .THR_STEP(THR_STEP)
    ) u_thresh (
        .clk(clk), .rst_n(rst_n), .rank_idle(rank_idle),
        .req_pending(req_pending), .busy(rank_busy), .backlog(backlog),
        .region(region), .thr_met(thr_met)
    );

    refsched_rfc_busy #(.T_RFC(T_RFC)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(rank_busy), .done(done)
    );

    // Request when free and either forced or the idle delay has elapsed.
    always_comb begin
        ref_urgent = (region == RG_FORCED);
        ref_req    = !rank_busy && (ref_urgent || thr_met);
        start      = ref_req && ref_issued;
    end
endmodule

// File: rtl/refsched_chk.sv
// Property checker for the elastic refresh scheduler, bound to the top.
module refsched_chk #(
    parameter int BL_MAX   = 8,
    parameter int ELIG_MIN = 2,
    parameter int BL_W     = $clog2(BL_MAX + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ref_issued,
    input logic            ref_req,
    input logic            ref_urgent,
    input logic            rank_busy,
    input logic [BL_W-1:0] backlog
);
    p_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(backlog) <= BL_MAX);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(backlog) <= int'($past(backlog)) + 1) &&
                 (int'($past(backlog)) <= int'(backlog) + 1));

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(backlog) < ELIG_MIN) |-> !ref_req);

    p_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent && !rank_busy) |-> ref_req);

    p_urgent_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (int'(backlog) == BL_MAX));

    p_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_issued && !ref_req && !rank_busy) |=> !rank_busy);

    p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_issued && ref_req) |=> rank_busy);

    p_no_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rank_busy |-> !ref_req);

    p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rank_busy) && (int'($past(backlog)) < BL_MAX) |->
            (int'(backlog) < int'($past(backlog))) || (backlog == $past(backlog)));
endmodule

bind elastic_refresh_sched refsched_chk #(
    .BL_MAX(BL_MAX), .ELIG_MIN(ELIG_MIN), .BL_W(BL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_issued(ref_issued), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .rank_busy(rank_busy), .backlog(backlog)
);

// File: tb/sim_elastic_refresh_sched.sv
`timescale 1ns/1ps
// Directed bench for the elastic refresh scheduler.
module sim_elastic_refresh_sched;
    localparam int T_REFI = 600;
    localparam int T_RFC  = 10;
    localparam int BL_MAX = 8;
    localparam int FLAT   = 48;
    localparam int STEP   = 16;
    localparam int BL_W   = $clog2(BL_MAX + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rank_idle = 1'b0;
    logic            req_pending = 1'b0;
    logic            ref_issued = 1'b0;
    logic            ref_req;
    logic            ref_urgent;
    logic            rank_busy;
    logic [BL_W-1:0] backlog;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    elastic_refresh_sched #(
        .T_REFI(T_REFI), .T_RFC(T_RFC), .BL_MAX(BL_MAX), .ELIG_MIN(2),
        .RAMP_START(5), .THR_FLAT(FLAT), .THR_STEP(STEP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rank_idle(rank_idle),
        .req_pending(req_pending), .ref_issued(ref_issued),
        .ref_req(ref_req), .ref_urgent(ref_urgent),
        .rank_busy(rank_busy), .backlog(backlog)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_bl(input int n);
        int guard = 0;
        while (int'(backlog) != n && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check("R2 backlog reached", int'(backlog), n);
    endtask

    // Go quiet and count cycles until the request appears.
    task automatic measure_idle(input string tag, input int exp);
        int n = 0;
        req_pending = 1'b0;
        rank_idle   = 1'b1;
        while (!ref_req && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(tag, n, exp);
    endtask

    // Accept the visible request, check the busy window and the debt drop.
    task automatic grant(input int exp_after);
        int n = 0;
        int rr = 0;
        check("R8 request visible before grant", int'(ref_req), 1);
        ref_issued = 1'b1;
        @(negedge clk);
        ref_issued  = 1'b0;
        req_pending = 1'b1;
        rank_idle   = 1'b0;
        while (rank_busy && n < 1000) begin
            n++;
            if (ref_req) rr++;
            @(negedge clk);
        end
        check("R8 busy length", n, T_RFC);
        check("R8 no request while busy", rr, 0);
        check("R9 backlog after refresh", int'(backlog), exp_after);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 req in reset", int'(ref_req), 0);
        check("R1 busy in reset", int'(rank_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req after reset", int'(ref_req), 0);
        check("R1 urgent after reset", int'(ref_urgent), 0);
        check("R1 busy after reset", int'(rank_busy), 0);
        check("R1 backlog after reset", int'(backlog), 0);
    endtask

    task automatic t_ignored_grant;
        ref_issued = 1'b1;
        @(negedge clk);
        ref_issued = 1'b0;
        check("R7 busy after stray grant", int'(rank_busy), 0);
        @(negedge clk);
        check("R7 busy one cycle later", int'(rank_busy), 0);
        check("R7 backlog unchanged", int'(backlog), 0);
    endtask

    task automatic t_low_backlog;
        int bad = 0;
        req_pending = 1'b0;
        rank_idle   = 1'b1;
        wait_bl(1);
        repeat (200) begin
            @(negedge clk);
            if (ref_req) bad++;
        end
        check("R3 no request at backlog 1", bad, 0);
    endtask

    task automatic t_flat_and_restart;
        req_pending = 1'b1;
        rank_idle   = 1'b0;
        wait_bl(2);
        req_pending = 1'b0;
        rank_idle   = 1'b1;
        repeat (30) @(negedge clk);
        check("R10 no request before delay", int'(ref_req), 0);
        req_pending = 1'b1;
        @(negedge clk);
        measure_idle("R10 R4 delay after restart at backlog 2", FLAT);
        grant(1);
    endtask

    task automatic t_forced_and_ramp;
        int n = 0;
        int mx = 0;
        req_pending = 1'b1;
        rank_idle   = 1'b0;
        wait_bl(3);
        while (int'(backlog) != 4 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check("R2 interval between increments", n, T_REFI);
        wait_bl(7);
        check("R6 no urgent below max", int'(ref_urgent), 0);
        check("R6 no request at 7 with traffic", int'(ref_req), 0);
        wait_bl(8);
        check("R6 urgent at max", int'(ref_urgent), 1);
        check("R6 request despite traffic", int'(ref_req), 1);
        repeat (2 * T_REFI + 5) begin
            @(negedge clk);
            if (int'(backlog) > mx) mx = int'(backlog);
        end
        check("R2 saturates at max", mx, BL_MAX);
        grant(7);
        check("R6 urgent cleared below max", int'(ref_urgent), 0);
        wait_bl(8);
        grant(7);
        measure_idle("R5 delay at backlog 7", STEP * 1);
        grant(6);
        measure_idle("R5 delay at backlog 6", STEP * 2);
        grant(5);
        measure_idle("R5 delay at backlog 5", STEP * 3);
        grant(4);
        measure_idle("R4 delay at backlog 4", FLAT);
        grant(3);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ignored_grant();
        t_low_backlog();
        t_flat_and_restart();
        t_forced_and_ramp();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule